// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM and watches it without driving it. On every rising clock edge it samples clock enable, chip select, the row and column strobes, write enable, the bank address and the auto-precharge address bit. It decodes the command, keeps an open/closed flag and a set of countdown timers for each bank, and judges the command against state and timing rules.

Each result is reported one clock after the command was sampled: the decoded command kind, the open-bank vector and, when a rule was broken, an error strobe with a one-hot code naming the rule and the bank involved. A rejected command leaves the bank state and all timers untouched, so one bad command does not cause a chain of follow-on errors. All delays are set in picoseconds and turned into whole clocks, rounded up, from a clock-period parameter. Control and status pins are plain levels; the block has no data stream and so no valid/ready handshake.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With clock enable high and chip select low, the active-low strobes (row, column, write) decode as: LLL mode set (kind 2), LLH refresh (3), LHH activate (4), HLH read (5), HLL write (6), HHL burst stop (8), LHL precharge (7), HHH no-operation (1); chip select high gives deselect (0); clock enable low gives power-down (9) whatever the other pins hold.
- R2: The bank address value is the bank index (0 to 3); a precharge with the auto-precharge bit high ignores the bank address and closes every open bank.
- R3: Outputs are registered: kind, error strobe, error code and error bank appear the clock after the command is sampled, the open-bank vector changes at that same edge, and error bank reads 0 when no error is flagged. After reset all outputs are 0.
- R4: A read or write to a closed bank, or an activate to an open bank, raises the state error (code bit 1).
- R5: A mode set while any bank is open raises code bit 2; a refresh while any bank is open raises code bit 3; the error bank is the lowest open bank.
- R6: Within MRD_CYC clocks after an accepted mode set, any command other than no-operation, deselect or power-down raises code bit 0.
- R7: A read or write less than the activate-to-column delay (3 clocks by default) after that bank's activate raises code bit 4.
- R8: A precharge of a bank open for less than the minimum active time (6 clocks) raises code bit 5; for precharge-all the error bank is the lowest bank that breaks it.
- R9: An activate earlier than the latest of row-cycle time (9 clocks) after the bank's previous activate, precharge time (3 clocks) after its close, and refresh cycle time (10 clocks) after a refresh raises code bit 6.
- R10: A read or write with the auto-precharge bit high closes the bank; the next activate to it must wait burst length (BURST_CYC = 2) plus precharge time after a read, and burst plus write recovery (2) plus precharge time after a write (7 clocks by default).
- R11: An activate less than the activate-to-activate gap (2 clocks) after an activate to any bank raises code bit 7.
- R12: Column commands closer than CCD_CYC clocks, or a read less than BURST_CYC + WTR_CYC (3) clocks after a write, raise code bit 8.
- R13: The error code is one-hot; when several rules break, the lowest bit wins. A rejected command changes no bank state and no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as sampled from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| ap | input | 1 | Auto-precharge / precharge-all address bit |
| cmd_kind | output | 4 | Decoded command kind (R1 codes) |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| err_valid | output | 1 | A rule was broken by the command |
| err_code | output | 9 | One-hot rule code |
| err_bank | output | 2 | Bank the error refers to |

## Verification
The bench plays one long legal-and-illegal command script, and each step pairs a command with its expected kind, code, bank and open vector. Pairs of the same command one clock apart, one too early and one exactly on time, pin each timer to its boundary and tell off-by-one load values from correct ones. Commands aimed at open versus closed banks, single-bank versus precharge-all closes, and auto-precharge reads versus writes separate the state rules from the timing rules. The exempt commands during the mode-set gap show that the gap check looks at the command kind rather than at every cycle.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;
  typedef enum logic [3:0] {
    K_DESEL = 4'd0, K_NOP = 4'd1, K_MODE = 4'd2, K_REFRESH = 4'd3,
    K_ACT = 4'd4, K_READ = 4'd5, K_WRITE = 4'd6, K_PRE = 4'd7,
    K_BSTOP = 4'd8, K_PDOWN = 4'd9
  } cmd_kind_e;

  localparam int ERR_W     = 9;
  localparam int E_MRD     = 0;
  localparam int E_STATE   = 1;
  localparam int E_MODEBSY = 2;
  localparam int E_REFBSY  = 3;
  localparam int E_RCD     = 4;
  localparam int E_RAS     = 5;
  localparam int E_ACTGAP  = 6;
  localparam int E_RRD     = 7;
  localparam int E_COL     = 8;

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
  import sdcg_pkg::*;
(
  input  logic      cke,
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind
);
  always_comb begin
    if (!cke)      kind = K_PDOWN;
    else if (cs_n) kind = K_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  kind = K_MODE;
        3'b001:  kind = K_REFRESH;
        3'b011:  kind = K_ACT;
        3'b101:  kind = K_READ;
        3'b100:  kind = K_WRITE;
        3'b110:  kind = K_BSTOP;
        3'b010:  kind = K_PRE;
        default: kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcg_bank_track.sv
module sdcg_bank_track #(
  parameter int TW    = 6,
  parameter int RCD_L = 2,
  parameter int RAS_L = 5,
  parameter int RC_L  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          close_i,
  input  logic [TW-1:0] close_gap_i,
  input  logic          hold_i,
  input  logic [TW-1:0] hold_gap_i,
  output logic          open_o,
  output logic          rcd_ok_o,
  output logic          ras_ok_o,
  output logic          act_ok_o
);
  localparam logic [TW-1:0] RCD_V = TW'(RCD_L);
  localparam logic [TW-1:0] RAS_V = TW'(RAS_L);
  localparam logic [TW-1:0] RC_V  = TW'(RC_L);

  logic          open_q;
  logic [TW-1:0] rcd_q, ras_q, act_q;
  logic [TW-1:0] rcd_dn, ras_dn, act_dn, act_nx;

  assign rcd_dn = (rcd_q == '0) ? '0 : rcd_q - 1'b1;
  assign ras_dn = (ras_q == '0) ? '0 : ras_q - 1'b1;
  assign act_dn = (act_q == '0) ? '0 : act_q - 1'b1;

  always_comb begin
    act_nx = act_dn;
    if (act_i)                               act_nx = RC_V;
    else if (close_i && close_gap_i > act_dn) act_nx = close_gap_i;
    else if (hold_i && hold_gap_i > act_dn)   act_nx = hold_gap_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      act_q  <= '0;
    end else begin
      if (act_i)        open_q <= 1'b1;
      else if (close_i) open_q <= 1'b0;
      rcd_q <= act_i ? RCD_V : rcd_dn;
      ras_q <= act_i ? RAS_V : ras_dn;
      act_q <= act_nx;
    end
  end

  assign open_o   = open_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign ras_ok_o = (ras_q == '0);
  assign act_ok_o = (act_q == '0);
endmodule

// File: rtl/sdcg_rules.sv
module sdcg_rules
  import sdcg_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input  cmd_kind_e        kind,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap,
  input  logic [NBANK-1:0] open_v,
  input  logic [NBANK-1:0] rcd_ok,
  input  logic [NBANK-1:0] ras_ok,
  input  logic [NBANK-1:0] act_ok,
  input  logic             mrd_busy,
  input  logic             rrd_busy,
  input  logic             ccd_busy,
  input  logic             wtr_busy,
  output logic [ERR_W-1:0] err_code,
  output logic [BA_W-1:0]  err_bank
);
  logic [ERR_W-1:0]  raw;
  logic [BA_W-1:0]   rule_bank [ERR_W];
  logic [NBANK-1:0]  ras_bad;
  logic [BA_W-1:0]   low_open, low_ras;
  logic              is_col, exempt;

  assign is_col = (kind == K_READ) || (kind == K_WRITE);
  assign exempt = (kind == K_NOP) || (kind == K_DESEL) || (kind == K_PDOWN);

  always_comb begin
    ras_bad = '0;
    for (int i = 0; i < NBANK; i++)
      ras_bad[i] = open_v[i] && !ras_ok[i] && (ap || (ba == BA_W'(i)));
  end

  always_comb begin
    low_open = '0;
    low_ras  = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (open_v[i])  low_open = BA_W'(i);
      if (ras_bad[i]) low_ras  = BA_W'(i);
    end
  end

  always_comb begin
    raw = '0;
    for (int r = 0; r < ERR_W; r++) rule_bank[r] = ba;
    raw[E_MRD]     = mrd_busy && !exempt;
    raw[E_STATE]   = (is_col && !open_v[ba]) || ((kind == K_ACT) && open_v[ba]);
    raw[E_MODEBSY] = (kind == K_MODE) && (|open_v);
    raw[E_REFBSY]  = (kind == K_REFRESH) && (|open_v);
    raw[E_RCD]     = is_col && open_v[ba] && !rcd_ok[ba];
    raw[E_RAS]     = (kind == K_PRE) && (|ras_bad);
    raw[E_ACTGAP]  = (kind == K_ACT) && !act_ok[ba];
    raw[E_RRD]     = (kind == K_ACT) && rrd_busy;
    raw[E_COL]     = (is_col && ccd_busy) || ((kind == K_READ) && wtr_busy);
    rule_bank[E_MODEBSY] = low_open;
    rule_bank[E_REFBSY]  = low_open;
    rule_bank[E_RAS]     = low_ras;
  end

  always_comb begin
    err_code = '0;
    err_bank = '0;
    for (int r = ERR_W - 1; r >= 0; r--) begin
      if (raw[r]) begin
        err_code    = '0;
        err_code[r] = 1'b1;
        err_bank    = rule_bank[r];
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdcg_pkg::*;
#(
  parameter int CLK_PS    = 7500,
  parameter int RCD_PS    = 20000,
  parameter int RP_PS     = 20000,
  parameter int RRD_PS    = 15000,
  parameter int RAS_PS    = 45000,
  parameter int RC_PS     = 65000,
  parameter int WR_PS     = 15000,
  parameter int RFC_PS    = 75000,
  parameter int MRD_CYC   = 2,
  parameter int CCD_CYC   = 1,
  parameter int WTR_CYC   = 1,
  parameter int BURST_CYC = 2,
  parameter int NBANK     = 4,
  parameter int BA_W      = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap,
  output logic [3:0]       cmd_kind,
  output logic [NBANK-1:0] bank_open,
  output logic             err_valid,
  output logic [ERR_W-1:0] err_code,
  output logic [BA_W-1:0]  err_bank
);
  localparam int RCD_C = ps_to_cyc(RCD_PS, CLK_PS);
  localparam int RP_C  = ps_to_cyc(RP_PS, CLK_PS);
  localparam int RRD_C = ps_to_cyc(RRD_PS, CLK_PS);
  localparam int RAS_C = ps_to_cyc(RAS_PS, CLK_PS);
  localparam int RC_C  = ps_to_cyc(RC_PS, CLK_PS);
  localparam int WR_C  = ps_to_cyc(WR_PS, CLK_PS);
  localparam int RFC_C = ps_to_cyc(RFC_PS, CLK_PS);
  localparam int TW    = $clog2(RFC_C + RC_C + RAS_C + BURST_CYC + WR_C + RP_C
                                + MRD_CYC + CCD_CYC + WTR_CYC + RRD_C + 2);
  localparam logic [TW-1:0] MRD_L  = TW'(MRD_CYC - 1);
  localparam logic [TW-1:0] RRD_L  = TW'(RRD_C - 1);
  localparam logic [TW-1:0] CCD_L  = TW'(CCD_CYC - 1);
  localparam logic [TW-1:0] WTR_L  = TW'(BURST_CYC + WTR_CYC - 1);
  localparam logic [TW-1:0] PRE_G  = TW'(RP_C - 1);
  localparam logic [TW-1:0] RDAP_G = TW'(BURST_CYC + RP_C - 1);
  localparam logic [TW-1:0] WRAP_G = TW'(BURST_CYC + WR_C + RP_C - 1);
  localparam logic [TW-1:0] RFC_G  = TW'(RFC_C - 1);

  cmd_kind_e        kind;
  logic [ERR_W-1:0] code_c;
  logic [BA_W-1:0]  bank_c;
  logic             accept;
  logic [NBANK-1:0] open_v, rcd_ok, ras_ok, act_ok;
  logic [TW-1:0]    mrd_q, rrd_q, ccd_q, wtr_q;
  logic [TW-1:0]    close_gap;
  logic             is_col;

  sdcg_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .kind(kind)
  );

  sdcg_rules #(.NBANK(NBANK), .BA_W(BA_W)) u_rules (
    .kind(kind), .ba(ba), .ap(ap), .open_v(open_v), .rcd_ok(rcd_ok),
    .ras_ok(ras_ok), .act_ok(act_ok),
    .mrd_busy(mrd_q != '0), .rrd_busy(rrd_q != '0),
    .ccd_busy(ccd_q != '0), .wtr_busy(wtr_q != '0),
    .err_code(code_c), .err_bank(bank_c)
  );

  assign accept = (code_c == '0);
  assign is_col = (kind == K_READ) || (kind == K_WRITE);

  always_comb begin
    close_gap = PRE_G;
    if (kind == K_READ)  close_gap = RDAP_G;
    if (kind == K_WRITE) close_gap = WRAP_G;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit, act_g, close_g;
    assign hit     = (ba == BA_W'(g));
    assign act_g   = accept && (kind == K_ACT) && hit;
    assign close_g = accept && open_v[g] &&
                     (((kind == K_PRE) && (ap || hit)) || (is_col && ap && hit));
    sdcg_bank_track #(
      .TW(TW), .RCD_L(RCD_C - 1), .RAS_L(RAS_C - 1), .RC_L(RC_C - 1)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .act_i(act_g), .close_i(close_g),
      .close_gap_i(close_gap), .hold_i(accept && (kind == K_REFRESH)),
      .hold_gap_i(RFC_G), .open_o(open_v[g]), .rcd_ok_o(rcd_ok[g]),
      .ras_ok_o(ras_ok[g]), .act_ok_o(act_ok[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_q <= '0; rrd_q <= '0; ccd_q <= '0; wtr_q <= '0;
      cmd_kind  <= K_DESEL;
      err_valid <= 1'b0;
      err_code  <= '0;
      err_bank  <= '0;
    end else begin
      mrd_q <= (accept && kind == K_MODE)  ? MRD_L : (mrd_q == '0 ? '0 : mrd_q - 1'b1);
      rrd_q <= (accept && kind == K_ACT)   ? RRD_L : (rrd_q == '0 ? '0 : rrd_q - 1'b1);
      ccd_q <= (accept && is_col)          ? CCD_L : (ccd_q == '0 ? '0 : ccd_q - 1'b1);
      wtr_q <= (accept && kind == K_WRITE) ? WTR_L : (wtr_q == '0 ? '0 : wtr_q - 1'b1);
      cmd_kind  <= kind;
      err_valid <= !accept;
      err_code  <= code_c;
      err_bank  <= bank_c;
    end
  end

  assign bank_open = open_v;
endmodule

// File: rtl/sdcg_guard_checker.sv
module sdcg_guard_checker
  import sdcg_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic [BA_W-1:0]  ba,
  input logic [3:0]       cmd_kind,
  input logic [NBANK-1:0] bank_open,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_code
);
  // R13: one-hot code that agrees with the strobe
  p_onehot_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_code) && (err_valid == (err_code != '0)));

  // R13: a rejected command leaves the bank vector unchanged
  p_reject_keeps_state_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> bank_open == $past(bank_open));

  // R4: an accepted activate leaves its bank open
  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind == 4'(K_ACT) && !err_valid) |-> bank_open[$past(ba)]);

  // R4: an accepted column command hit a bank that was open
  p_col_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_kind == 4'(K_READ) || cmd_kind == 4'(K_WRITE)) && !err_valid)
      |-> $past(bank_open[ba]));

  // R5: an accepted mode set or refresh leaves every bank closed
  p_mode_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_kind == 4'(K_MODE) || cmd_kind == 4'(K_REFRESH)) && !err_valid)
      |-> bank_open == '0);

  // R1: clock enable low is reported as power-down and never as an error
  p_pdown_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cmd_kind == 4'(K_PDOWN)) && !err_valid);
endmodule

bind sdram_cmd_guard sdcg_guard_checker #(.NBANK(NBANK), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .ba(ba), .cmd_kind(cmd_kind),
  .bank_open(bank_open), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/sdram_cmd_guard_bench.sv
`timescale 1ns/1ps
module sdram_cmd_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] KD = 0, KN = 1, KM = 2, KF = 3, KA = 4, KR = 5,
                         KW = 6, KP = 7, KB = 8, KZ = 9;
  localparam logic [8:0] OK = 9'h000, EMRD = 9'h001, EST = 9'h002,
                         EMB = 9'h004, ERB = 9'h008, ERCD = 9'h010,
                         ERAS = 9'h020, EGAP = 9'h040, ERRD = 9'h080,
                         ECOL = 9'h100;

  typedef struct {
    logic [3:0] kind;
    logic [8:0] code;
    logic [1:0] bank;
    logic [3:0] open;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_kind, bank_open;
  logic       err_valid;
  logic [8:0] err_code;
  logic [1:0] err_bank;
  int checks = 0, fails = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_guard u_sdram_cmd_guard (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .cmd_kind(cmd_kind),
    .bank_open(bank_open), .err_valid(err_valid), .err_code(err_code),
    .err_bank(err_bank)
  );

  task automatic issue(input logic [3:0] k, input int b, input logic a,
                       input logic [8:0] code, input int eb,
                       input logic [3:0] op, input string tag);
    exp_t e;
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b0; ba = 2'(b); ap = a;
    case (k)
      KM: {ras_n, cas_n, we_n} = 3'b000;
      KF: {ras_n, cas_n, we_n} = 3'b001;
      KA: {ras_n, cas_n, we_n} = 3'b011;
      KR: {ras_n, cas_n, we_n} = 3'b101;
      KW: {ras_n, cas_n, we_n} = 3'b100;
      KB: {ras_n, cas_n, we_n} = 3'b110;
      KP: {ras_n, cas_n, we_n} = 3'b010;
      KD: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
      KZ: begin cke = 1'b0; {ras_n, cas_n, we_n} = 3'b011; end
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    e.kind = k; e.code = code; e.bank = 2'(eb); e.open = op; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nops(input int n, input logic [3:0] op);
    for (int i = 0; i < n; i++) issue(KN, 0, 1'b0, OK, 0, op, "R1");
  endtask

  // monitor: results of a command appear after the following rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cmd_kind !== e.kind || err_code !== e.code || err_bank !== e.bank ||
          bank_open !== e.open || err_valid !== (e.code != 0)) begin
        fails++;
        $display("FAIL %s: kind=%0d code=%h bank=%0d open=%b valid=%b expected kind=%0d code=%h bank=%0d open=%b",
                 e.tag, cmd_kind, err_code, err_bank, bank_open, err_valid,
                 e.kind, e.code, e.bank, e.open);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cmd_kind !== 4'd0 || err_valid !== 1'b0 || bank_open !== 4'd0 || err_code !== 9'd0) begin
      fails++;
      $display("FAIL R3 reset: kind=%0d valid=%b open=%b code=%h expected 0 0 0000 000",
               cmd_kind, err_valid, bank_open, err_code);
    end
    issue(KM, 0, 0, OK,   0, 4'b0000, "R1 mode set");
    issue(KA, 0, 0, EMRD, 0, 4'b0000, "R6 gap");
    issue(KA, 0, 0, OK,   0, 4'b0001, "R2 act bank0");
    issue(KA, 1, 0, ERRD, 1, 4'b0001, "R11 rrd early");
    issue(KA, 1, 0, OK,   0, 4'b0011, "R11 rrd on time");
    issue(KR, 1, 0, ERCD, 1, 4'b0011, "R7 rcd early");
    issue(KR, 0, 0, OK,   0, 4'b0011, "R7 rcd on time");
    issue(KW, 0, 0, OK,   0, 4'b0011, "R1 write");
    issue(KR, 1, 0, ECOL, 1, 4'b0011, "R12 write-to-read");
    issue(KP, 0, 0, OK,   0, 4'b0010, "R8 pre after ras");
    issue(KR, 1, 0, OK,   0, 4'b0010, "R12 read after wtr");
    issue(KA, 0, 0, EGAP, 0, 4'b0010, "R9 rp early");
    issue(KA, 0, 0, OK,   0, 4'b0011, "R9 rp on time");
    issue(KP, 0, 0, ERAS, 0, 4'b0011, "R8 ras early");
    issue(KR, 2, 0, EST,  2, 4'b0011, "R4 read closed");
    issue(KA, 1, 0, EST,  1, 4'b0011, "R4 act open");
    issue(KM, 0, 0, EMB,  0, 4'b0011, "R5 mode busy");
    issue(KF, 0, 0, ERB,  0, 4'b0011, "R5 refresh busy");
    issue(KP, 3, 1, OK,   0, 4'b0000, "R2 precharge all");
    issue(KA, 2, 0, OK,   0, 4'b0100, "R2 act bank2");
    nops(2, 4'b0100);
    issue(KW, 2, 1, OK,   0, 4'b0000, "R10 write autopre");
    issue(KA, 3, 0, OK,   0, 4'b1000, "R2 act bank3");
    nops(4, 4'b1000);
    issue(KA, 2, 0, EGAP, 2, 4'b1000, "R10 dal early");
    issue(KA, 2, 0, OK,   0, 4'b1100, "R10 dal on time");
    issue(KP, 0, 1, ERAS, 2, 4'b1100, "R8 precharge all early");
    nops(4, 4'b1100);
    issue(KP, 0, 1, OK,   0, 4'b0000, "R8 precharge all ok");
    issue(KF, 0, 0, OK,   0, 4'b0000, "R5 refresh idle");
    issue(KA, 0, 0, EGAP, 0, 4'b0000, "R9 rfc early");
    issue(KM, 0, 0, OK,   0, 4'b0000, "R5 mode idle");
    issue(KN, 0, 0, OK,   0, 4'b0000, "R6 nop exempt");
    issue(KD, 0, 0, OK,   0, 4'b0000, "R1 deselect");
    issue(KZ, 0, 0, OK,   0, 4'b0000, "R1 power-down");
    issue(KB, 0, 0, OK,   0, 4'b0000, "R13 burst stop");
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL R3: %0d results missing, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule